// File: doc/BRIEF.md
# Periodic Bus Activity Sampling Counter

This block is a passive observer for a synchronous bus. On every bus clock it decides whether the cycle carried traffic. It adds each such cycle to a saturating accumulator. At the close of every fixed-length interval it emits one record and clears the accumulator. Software or a trace buffer can then turn a long run into a throughput profile. It never decodes addresses or data, and it never stores individual bus states. It only stores one snapshot of the count per interval.

Three qualifier rules are selectable, one for each kind of bus:

- A shared parallel bus, where a cycle is idle only when both active-low strobes, frame and initiator-ready, are high.
- A memory-module command bus, where a cycle is an access when one of the active-low chip selects is low together with the column strobe. The write-enable line can optionally split accesses into reads and writes.
- A double-rate graphics data strobe, where each active strobe cycle counts.

Each record carries a byte figure scaled for the chosen bus. Records leave through a valid/ready handshake.

After an arm pulse, the first interval only aligns the timer and produces no record. Every later interval yields one record, or sets a sticky lost flag if the previous record is still waiting.

Top module: `bus_activity_sampler`

## Requirements
- R1: After synchronous reset, rec_valid_o and rec_lost_o are 0, and nothing is counted until arm_i is pulsed.
- R2: After an arm pulse, the first INTERVAL clocks are discarded and give no record. The first record reports the second interval and has index 0.
- R3: With mode code 0 (shared bus), a clock counts unless frame_n_i and irdy_n_i are both 1. rec_bytes_o equals the count times 4.
- R4: With mode code 1 (memory module) and the split disabled, a clock counts when any bit of cs_n_i is 0 and cas_n_i is 0. rec_bytes_o equals the count times 8 and rec_wcount_o is 0.
- R5: With mode code 1 and the split enabled, an access with we_n_i=1 adds to rec_count_o and an access with we_n_i=0 adds to rec_wcount_o. rec_bytes_o equals their sum times 8. In other modes rec_wcount_o is 0.
- R6: With mode code 2 (graphics strobe), a clock counts when stb_i is 1, and rec_bytes_o equals the count times 8. Mode code 3 counts nothing.
- R7: Each interval lasts exactly INTERVAL clocks. The counts restart from zero for every interval, and rec_index_o rises by one per interval after the discarded one.
- R8: mode_i and split_i are sampled only at arm and at interval boundaries. A change in mid-interval applies from the next interval, and rec_mode_o reports the mode that was used.
- R9: A count that reaches 2^CNT_W-1 holds there instead of wrapping, and rec_ovf_o is set in that record.
- R10: A record stays valid and unchanged until rec_ready_i is 1. If a new record is due while one is still held, the new one is dropped, its index is skipped, and rec_lost_o becomes 1 and stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| arm_i | input | 1 | Pulse: start (or restart) sampling |
| mode_i | input | 2 | Qualifier mode: 0 shared bus, 1 memory module, 2 graphics strobe, 3 none |
| split_i | input | 1 | Split memory accesses into read and write counts |
| frame_n_i | input | 1 | Shared bus frame strobe, active low |
| irdy_n_i | input | 1 | Shared bus initiator-ready, active low |
| cs_n_i | input | CS_N | Memory chip selects, active low |
| cas_n_i | input | 1 | Memory column strobe, active low |
| we_n_i | input | 1 | Memory write enable, active low |
| stb_i | input | 1 | Graphics data strobe active |
| rec_ready_i | input | 1 | Record consumer ready |
| rec_valid_o | output | 1 | Record valid |
| rec_index_o | output | IDX_W | Interval index of the record |
| rec_count_o | output | CNT_W | Qualified count (reads when split) |
| rec_wcount_o | output | CNT_W | Write count when split, else 0 |
| rec_bytes_o | output | CNT_W+4 | Scaled byte figure |
| rec_mode_o | output | 2 | Mode used for this interval |
| rec_ovf_o | output | 1 | A count saturated in this interval |
| rec_lost_o | output | 1 | Sticky: a record was dropped |

## Verification
The hardest condition to reach is the dropped record. It needs one record held unaccepted for a whole interval, and the following record must then show the skipped index and the sticky flag. The bench withholds the ready pulse for one interval and checks the held record again at the next boundary, before it accepts it. Saturation needs more qualifying clocks than the count width can hold. A second instance with a 3-bit count watches the same all-busy interval as the main one. Mid-interval mode changes are driven halfway through an interval and are checked against the mode reported in the following records.

// File: rtl/bas_pkg.sv
package bas_pkg;
  typedef enum logic [1:0] {
    MODE_SHARED = 2'd0,
    MODE_MEMCMD = 2'd1,
    MODE_STROBE = 2'd2,
    MODE_NONE   = 2'd3
  } bas_mode_e;
endpackage

// File: rtl/bas_qualifier.sv
module bas_qualifier
  import bas_pkg::*;
#(
  parameter int unsigned CS_N = 4
) (
  input  bas_mode_e       mode,
  input  logic            split,
  input  logic            frame_n,
  input  logic            irdy_n,
  input  logic [CS_N-1:0] cs_n,
  input  logic            cas_n,
  input  logic            we_n,
  input  logic            stb,
  output logic            hit_a,
  output logic            hit_b
);
  logic mem_access;

  assign mem_access = ~(&cs_n) & ~cas_n;

  always_comb begin
    hit_a = 1'b0;
    hit_b = 1'b0;
    case (mode)
      MODE_SHARED: hit_a = ~(frame_n & irdy_n);
      MODE_MEMCMD: begin
        if (split) begin
          hit_a = mem_access & we_n;
          hit_b = mem_access & ~we_n;
        end else begin
          hit_a = mem_access;
        end
      end
      MODE_STROBE: hit_a = stb;
      default: ;
    endcase
  end
endmodule

// File: rtl/bas_sat_counter.sv
module bas_sat_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt_next,
  output logic         ovf_next
);
  localparam logic [W-1:0] MAX = {W{1'b1}};

  logic [W-1:0] cnt;
  logic         ovf;
  logic         at_max;

  assign at_max   = (cnt == MAX);
  assign cnt_next = (inc && !at_max) ? cnt + 1'b1 : cnt;
  assign ovf_next = ovf | (inc & at_max);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
      ovf <= 1'b0;
    end else begin
      cnt <= cnt_next;
      ovf <= ovf_next;
    end
  end
endmodule

// File: rtl/bas_interval_timer.sv
module bas_interval_timer #(
  parameter int unsigned INTERVAL = 10_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic run,
  output logic last
);
  localparam int unsigned TW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam logic [TW-1:0] END_VAL = TW'(INTERVAL - 1);

  logic [TW-1:0] tmr;

  assign last = run && (tmr == END_VAL);

  always_ff @(posedge clk) begin
    if (rst || start) begin
      tmr <= '0;
    end else if (run) begin
      tmr <= last ? '0 : tmr + 1'b1;
    end
  end
endmodule

// File: rtl/bus_activity_sampler.sv
module bus_activity_sampler
  import bas_pkg::*;
#(
  parameter int unsigned INTERVAL = 10_000_000,
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned IDX_W    = 16,
  parameter int unsigned CS_N     = 4,
  localparam int unsigned BYTES_W = CNT_W + 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               arm_i,
  input  logic [1:0]         mode_i,
  input  logic               split_i,
  input  logic               frame_n_i,
  input  logic               irdy_n_i,
  input  logic [CS_N-1:0]    cs_n_i,
  input  logic               cas_n_i,
  input  logic               we_n_i,
  input  logic               stb_i,
  input  logic               rec_ready_i,
  output logic               rec_valid_o,
  output logic [IDX_W-1:0]   rec_index_o,
  output logic [CNT_W-1:0]   rec_count_o,
  output logic [CNT_W-1:0]   rec_wcount_o,
  output logic [BYTES_W-1:0] rec_bytes_o,
  output logic [1:0]         rec_mode_o,
  output logic               rec_ovf_o,
  output logic               rec_lost_o
);
  localparam int unsigned LANES = 2;

  logic       armed;
  logic       warm;
  logic       split_q;
  bas_mode_e  mode_q;
  logic [IDX_W-1:0] idx;

  logic       last;
  logic       clr;
  logic [LANES-1:0] hit;
  logic [LANES-1:0] inc;
  logic [LANES-1:0] ovf_n;
  logic [CNT_W-1:0] cnt_n [LANES];
  logic [CNT_W:0]   sum;
  logic [BYTES_W-1:0] bytes;

  bas_qualifier #(.CS_N(CS_N)) u_qual (
    .mode    (mode_q),
    .split   (split_q),
    .frame_n (frame_n_i),
    .irdy_n  (irdy_n_i),
    .cs_n    (cs_n_i),
    .cas_n   (cas_n_i),
    .we_n    (we_n_i),
    .stb     (stb_i),
    .hit_a   (hit[0]),
    .hit_b   (hit[1])
  );

  bas_interval_timer #(.INTERVAL(INTERVAL)) u_tmr (
    .clk   (clk),
    .rst   (rst),
    .start (arm_i),
    .run   (armed),
    .last  (last)
  );

  assign clr = arm_i | last;

  // lane 0: total or read count, lane 1: write count
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign inc[g] = hit[g] & armed & ~arm_i;
    bas_sat_counter #(.W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst      (rst),
      .clr      (clr),
      .inc      (inc[g]),
      .cnt_next (cnt_n[g]),
      .ovf_next (ovf_n[g])
    );
  end

  assign sum = {1'b0, cnt_n[0]} + {1'b0, cnt_n[1]};

  always_comb begin
    case (mode_q)
      MODE_SHARED: bytes = {3'b000, sum} << 2;
      MODE_MEMCMD,
      MODE_STROBE: bytes = {3'b000, sum} << 3;
      default:     bytes = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed        <= 1'b0;
      warm         <= 1'b0;
      split_q      <= 1'b0;
      mode_q       <= MODE_SHARED;
      idx          <= '0;
      rec_valid_o  <= 1'b0;
      rec_index_o  <= '0;
      rec_count_o  <= '0;
      rec_wcount_o <= '0;
      rec_bytes_o  <= '0;
      rec_mode_o   <= 2'd0;
      rec_ovf_o    <= 1'b0;
      rec_lost_o   <= 1'b0;
    end else begin
      if (rec_valid_o && rec_ready_i) begin
        rec_valid_o <= 1'b0;
      end
      if (arm_i) begin
        armed   <= 1'b1;
        warm    <= 1'b1;
        mode_q  <= bas_mode_e'(mode_i);
        split_q <= split_i;
        idx     <= '0;
      end else if (last) begin
        mode_q  <= bas_mode_e'(mode_i);
        split_q <= split_i;
        warm    <= 1'b0;
        if (!warm) begin
          idx <= idx + 1'b1;
          if (!rec_valid_o || rec_ready_i) begin
            rec_valid_o  <= 1'b1;
            rec_index_o  <= idx;
            rec_count_o  <= cnt_n[0];
            rec_wcount_o <= cnt_n[1];
            rec_bytes_o  <= bytes;
            rec_mode_o   <= mode_q;
            rec_ovf_o    <= |ovf_n;
          end else begin
            rec_lost_o <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/bas_checker.sv
module bas_checker
  import bas_pkg::*;
#(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned IDX_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             rec_valid_o,
  input logic             rec_ready_i,
  input logic [IDX_W-1:0] rec_index_o,
  input logic [CNT_W-1:0] rec_count_o,
  input logic [CNT_W-1:0] rec_wcount_o,
  input logic [1:0]       rec_mode_o,
  input logic             rec_ovf_o,
  input logic             rec_lost_o
);
  localparam logic [CNT_W-1:0] MAX = {CNT_W{1'b1}};

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!rec_valid_o && !rec_lost_o));

  assert_record_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (rec_valid_o && !rec_ready_i) |=>
      (rec_valid_o && $stable(rec_index_o) && $stable(rec_count_o) && $stable(rec_wcount_o)));

  assert_lost_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    rec_lost_o |=> rec_lost_o);

  assert_wcount_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (rec_valid_o && rec_mode_o != MODE_MEMCMD) |-> (rec_wcount_o == '0));

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
    (rec_valid_o && rec_ovf_o) |-> ((rec_count_o == MAX) || (rec_wcount_o == MAX)));
endmodule

bind bus_activity_sampler bas_checker #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .rec_valid_o  (rec_valid_o),
  .rec_ready_i  (rec_ready_i),
  .rec_index_o  (rec_index_o),
  .rec_count_o  (rec_count_o),
  .rec_wcount_o (rec_wcount_o),
  .rec_mode_o   (rec_mode_o),
  .rec_ovf_o    (rec_ovf_o),
  .rec_lost_o   (rec_lost_o)
);

// File: tb/bus_activity_sampler_tb.sv
module bus_activity_sampler_tb;
  localparam int CLK_PERIOD = 10;
  localparam int INTERVAL   = 16;
  localparam int CNT_W      = 32;
  localparam int IDX_W      = 16;
  localparam int SMALL_W    = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic arm_i = 1'b0;
  logic [1:0] mode_i = 2'd0;
  logic split_i = 1'b0;
  logic frame_n_i = 1'b1, irdy_n_i = 1'b1, cas_n_i = 1'b1, we_n_i = 1'b1, stb_i = 1'b0;
  logic [3:0] cs_n_i = 4'hF;
  logic rec_ready_i = 1'b0;

  logic             rec_valid_o;
  logic [IDX_W-1:0] rec_index_o;
  logic [CNT_W-1:0] rec_count_o, rec_wcount_o;
  logic [CNT_W+3:0] rec_bytes_o;
  logic [1:0]       rec_mode_o;
  logic             rec_ovf_o, rec_lost_o;

  logic               s_valid;
  logic [IDX_W-1:0]   s_index;
  logic [SMALL_W-1:0] s_count, s_wcount;
  logic [SMALL_W+3:0] s_bytes;
  logic [1:0]         s_mode;
  logic               s_ovf, s_lost;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_activity_sampler #(.INTERVAL(INTERVAL), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_dut (
    .clk(clk), .rst(rst), .arm_i(arm_i), .mode_i(mode_i), .split_i(split_i),
    .frame_n_i(frame_n_i), .irdy_n_i(irdy_n_i), .cs_n_i(cs_n_i), .cas_n_i(cas_n_i),
    .we_n_i(we_n_i), .stb_i(stb_i), .rec_ready_i(rec_ready_i),
    .rec_valid_o(rec_valid_o), .rec_index_o(rec_index_o), .rec_count_o(rec_count_o),
    .rec_wcount_o(rec_wcount_o), .rec_bytes_o(rec_bytes_o), .rec_mode_o(rec_mode_o),
    .rec_ovf_o(rec_ovf_o), .rec_lost_o(rec_lost_o)
  );

  bus_activity_sampler #(.INTERVAL(INTERVAL), .CNT_W(SMALL_W), .IDX_W(IDX_W)) u_dut_small (
    .clk(clk), .rst(rst), .arm_i(arm_i), .mode_i(mode_i), .split_i(split_i),
    .frame_n_i(frame_n_i), .irdy_n_i(irdy_n_i), .cs_n_i(cs_n_i), .cas_n_i(cas_n_i),
    .we_n_i(we_n_i), .stb_i(stb_i), .rec_ready_i(1'b1),
    .rec_valid_o(s_valid), .rec_index_o(s_index), .rec_count_o(s_count),
    .rec_wcount_o(s_wcount), .rec_bytes_o(s_bytes), .rec_mode_o(s_mode),
    .rec_ovf_o(s_ovf), .rec_lost_o(s_lost)
  );

  int n_checks = 0;
  int n_fail   = 0;

  // bench model
  logic [15:0] lfsr = 16'hACE1;
  logic [1:0] m_mode;
  bit   m_split, m_pend, m_lost, p_split, chk_small;
  int   m_idx, p_idx, p_a, p_b, small_exp;
  logic [1:0] p_mode;

  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic string tag(input logic [1:0] md, input bit sp);
    case (md)
      2'd0: return "R3";
      2'd1: return sp ? "R5" : "R4";
      default: return "R6";
    endcase
  endfunction

  function automatic longint scale(input logic [1:0] md, input longint n);
    case (md)
      2'd0: return n * 4;
      2'd1, 2'd2: return n * 8;
      default: return 0;
    endcase
  endfunction

  task automatic check_record();
    check("R10", "valid held", longint'(rec_valid_o), 1);
    check("R7", "index", longint'(rec_index_o), p_idx);
    check(tag(p_mode, p_split), "count", longint'(rec_count_o), p_a);
    check("R5", "wcount", longint'(rec_wcount_o), p_b);
    check(tag(p_mode, p_split), "bytes", longint'(rec_bytes_o), scale(p_mode, p_a + p_b));
    check("R8", "mode", longint'(rec_mode_o), longint'(p_mode));
    check("R9", "ovf clear", longint'(rec_ovf_o), 0);
    check("R10", "lost flag", longint'(rec_lost_o), longint'(m_lost));
  endtask

  // act: 0 idle, 1 pseudo-random, 2 all busy
  task automatic drive(input int act, output bit ha, output bit hb);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (act)
      0: begin
        frame_n_i = 1; irdy_n_i = 1; cs_n_i = 4'hF; cas_n_i = 1; we_n_i = 1; stb_i = 0;
      end
      1: begin
        frame_n_i = lfsr[0] | lfsr[1]; irdy_n_i = lfsr[2];
        cs_n_i = lfsr[7] ? 4'hF : ~(4'b0001 << lfsr[4:3]);
        cas_n_i = lfsr[8]; we_n_i = lfsr[9]; stb_i = lfsr[10] ^ lfsr[11];
      end
      default: begin
        frame_n_i = 0; irdy_n_i = 0; cs_n_i = 4'h0; cas_n_i = 0; we_n_i = lfsr[5]; stb_i = 1;
      end
    endcase
    ha = 0; hb = 0;
    case (m_mode)
      2'd0: ha = !(frame_n_i && irdy_n_i);
      2'd1: begin
        if (cs_n_i != 4'hF && !cas_n_i) begin
          if (m_split && !we_n_i) hb = 1; else ha = 1;
        end
      end
      2'd2: ha = stb_i;
      default: ;
    endcase
  endtask

  task automatic run_interval(input bit report, input int act, input bit accept,
                              input bit sw, input logic [1:0] sw_mode);
    int ea = 0;
    int eb = 0;
    bit ha, hb;
    for (int i = 0; i < INTERVAL; i++) begin
      @(negedge clk);
      arm_i = 0;
      if (i == 0) begin
        if (m_pend) begin
          check_record();
          if (accept) begin
            rec_ready_i = 1;
            m_pend = 0;
          end
        end else begin
          check("R2", "no record pending", longint'(rec_valid_o), 0);
        end
        if (chk_small) begin
          check("R9", "small count saturates", longint'(s_count), small_exp > 7 ? 7 : small_exp);
          check("R9", "small ovf flag", longint'(s_ovf), small_exp > 7 ? 1 : 0);
          check("R9", "small bytes", longint'(s_bytes), (small_exp > 7 ? 7 : small_exp) * 4);
          chk_small = 0;
        end
      end else begin
        rec_ready_i = 0;
      end
      if (sw && i == INTERVAL / 2) mode_i = sw_mode;
      drive(act, ha, hb);
      ea += int'(ha);
      eb += int'(hb);
    end
    if (report) begin
      if (m_pend) begin
        m_lost = 1;
      end else begin
        m_pend = 1; p_idx = m_idx; p_a = ea; p_b = eb; p_mode = m_mode; p_split = m_split;
      end
      m_idx++;
      small_exp = ea;
    end
    m_mode = mode_i;
    m_split = split_i;
  endtask

  task automatic flush();
    @(negedge clk);
    if (m_pend) check_record();
    rec_ready_i = 1;
    m_pend = 0;
    @(negedge clk);
    rec_ready_i = 0;
    check("R10", "valid cleared after accept", longint'(rec_valid_o), 0);
  endtask

  task automatic arm(input logic [1:0] md, input bit sp);
    @(negedge clk);
    arm_i = 1; mode_i = md; split_i = sp; rec_ready_i = 0;
    m_mode = md; m_split = sp; m_idx = 0;
  endtask

  task automatic test_reset();
    rst = 1;
    repeat (3) @(negedge clk);
    check("R1", "valid after reset", longint'(rec_valid_o), 0);
    check("R1", "lost after reset", longint'(rec_lost_o), 0);
    rst = 0;
    repeat (INTERVAL + 2) @(negedge clk);
    check("R1", "no record while unarmed", longint'(rec_valid_o), 0);
  endtask

  task automatic test_modes();
    arm(2'd0, 0);
    run_interval(0, 1, 1, 0, 2'd0);   // discarded first interval (R2)
    run_interval(1, 1, 1, 0, 2'd0);   // shared bus random (R3, R2 check at start)
    run_interval(1, 2, 1, 0, 2'd0);   // shared bus all busy, checks record above
    chk_small = 1;                    // small instance saturates on all-busy interval (R9)
    run_interval(1, 1, 1, 1, 2'd1);   // switch to memory mode in mid-interval (R8)
    run_interval(1, 1, 1, 0, 2'd1);   // memory mode random (R4)
    run_interval(1, 0, 1, 1, 2'd2);   // memory idle, switch to strobe (R7 clear)
    run_interval(1, 1, 1, 0, 2'd2);   // strobe mode (R6)
  endtask

  task automatic test_lost();
    run_interval(1, 1, 0, 0, 2'd2);   // hold previous record: next is dropped (R10)
    run_interval(1, 1, 1, 0, 2'd2);   // held record still intact, lost set
    run_interval(1, 0, 1, 0, 2'd2);   // index skips dropped record
    flush();
  endtask

  task automatic test_split();
    arm(2'd1, 1);
    run_interval(0, 1, 1, 0, 2'd1);
    run_interval(1, 1, 1, 0, 2'd1);   // split read/write (R5)
    run_interval(1, 2, 1, 0, 2'd1);   // split all busy
    flush();
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_fail++;
    $display("FAIL R7 watchdog: actual hung expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    m_mode = 0; m_split = 0; m_pend = 0; m_lost = 0; chk_small = 0;
    m_idx = 0; p_idx = 0; p_a = 0; p_b = 0; p_mode = 0; p_split = 0; small_exp = 0;
    test_reset();
    test_modes();
    test_lost();
    test_split();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule